// File: doc/BRIEF.md
# Programmable Interrupt and Port Interface

This block is a peripheral on a bit-serial host bus. It looks after 22 external pins in three groups. The first group holds six pins that are always inputs; they can raise interrupts 1 to 6, and their levels can be read. The second group holds nine pins that serve as interrupts 7 to 15 and also as ports 15 down to 7. Each of these pins can be an interrupt source, a plain input or a driven output. The third group holds seven pins, ports 0 to 6, and each one is either an input or an output.

Interrupt inputs are active low. Each interrupt has its own enable bit. The block picks the lowest-numbered interrupt that is enabled and active, and shows its number to the processor as a 4-bit level code together with an active-low request line. The host reaches the block one bit at a time. It drives a select, a 5-bit bit address and a write data bit, and pulses a write strobe to update one bit. During a read, the addressed bit comes back on a single read data line.

Top module: `irq_port_unit`

## Requirements
- R1: After reset no pin is driven (pin_oe all 0), every interrupt enable bit is clear, irq_req_n is 1 and irq_code is 0.
- R2: Pins 0 to 5 (interrupts 1 to 6) are never driven. Their synchronised levels read back at bit addresses 1 to 6.
- R3: A write to bit address n, for n from 1 to 15, sets the enable of interrupt n to the written bit. A write to bit address 16+k, for k from 0 to 15, sets the output value of port k. A write to bit address 0 changes nothing.
- R4: The first write to the output bit of port k turns its pin into a driven output carrying the written value. Later writes change only the value. Only reset turns the pin back into an input.
- R5: A read at a bit address returns the synchronised live level of the pin behind it. Port k for k from 0 to 6 is pin 15+k. Port k for k from 7 to 15 is pin 21-k, which is the pin of interrupt 22-k. Interrupt n is pin n-1.
- R6: While bus_sel is 0, bus_rdat is 0 and write strobes change nothing.
- R7: Interrupt n is active when its enable bit is 1, its pin is low, and its pin is not a driven output.
- R8: When one or more interrupts are active, irq_req_n is 0 and irq_code gives the lowest active interrupt number.
- R9: When no interrupt is active, irq_req_n is 1 and irq_code is 0.
- R10: A pin edge reaches bus_rdat after two rising clock edges and reaches irq_code and irq_req_n after three.
- R11: A pin that is low never raises a request while its enable bit is clear, or while it is a driven output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host select for this peripheral |
| bus_addr | input | 5 | Bit address |
| bus_wdat | input | 1 | Serial write data bit |
| bus_wstb | input | 1 | Write strobe, one bit per pulse |
| bus_rdat | output | 1 | Serial read data bit |
| pin_in | input | 22 | Levels seen on the external pins |
| pin_out | output | 22 | Values driven onto the pins |
| pin_oe | output | 22 | Per-pin drive enable |
| irq_code | output | 4 | Number of the winning interrupt, 0 when idle |
| irq_req_n | output | 1 | Active-low interrupt request |

## Verification
A corrupted enable bit shows up three clock edges after the pin goes low. Either a request appears that should be missing, or the code names the wrong interrupt. A direction latch in the wrong state shows up at once on pin_oe, and a wrong output value shows up at once on pin_out. A swapped entry in the port-to-pin map reads back the wrong level two edges after the pin changes. The same fault can also drive the wrong pin as soon as the write lands. A broken priority chain is exposed on the same cycle as a correct request, whenever two enabled pins are low together.

// File: rtl/irq_port_pkg.sv
package irq_port_pkg;

   // Pin index behind port k
   function automatic int port_pin(int k, int g1, int g2, int g3);
      if (k < g3) return g1 + g2 + k;
      return g1 + (g3 + g2 - 1 - k);
   endfunction

   // Port number behind a group-two pin p
   function automatic int pin_port(int p, int g1, int g2, int g3);
      return g3 + g2 - 1 - (p - g1);
   endfunction

endpackage

// File: rtl/irq_port_sync.sv
module irq_port_sync #(
   parameter int W      = 22,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage[s] <= '1;
      end else begin
         stage[0] <= d;
         for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_port_regs.sv
module irq_port_regs #(
   parameter int NINT      = 15,
   parameter int NPORT     = 16,
   parameter int ADDR_W    = 5,
   parameter int PORT_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wstb,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wdat,
   output logic [NINT-1:0]   irq_en,
   output logic [NPORT-1:0]  port_val,
   output logic [NPORT-1:0]  port_dir
);
   int a;
   always_comb a = int'(bus_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en   <= '0;
         port_val <= '0;
         port_dir <= '0;
      end else if (bus_sel && bus_wstb) begin
         for (int i = 0; i < NINT; i++)
            if (a == i + 1) irq_en[i] <= bus_wdat;
         for (int k = 0; k < NPORT; k++)
            if (a == PORT_BASE + k) begin
               port_val[k] <= bus_wdat;
               port_dir[k] <= 1'b1;
            end
      end
   end
endmodule

// File: rtl/irq_port_prio.sv
module irq_port_prio #(
   parameter int NINT    = 15,
   parameter int CODE_W  = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NINT-1:0]   act,
   output logic [CODE_W-1:0] code,
   output logic              req_n
);
   logic [CODE_W-1:0] code_c;
   logic              any_c;

   always_comb begin
      code_c = '0;
      for (int i = NINT - 1; i >= 0; i--)
         if (act[i]) code_c = CODE_W'(i + 1);
      any_c = |act;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            code  <= '0;
            req_n <= 1'b1;
         end else begin
            code  <= code_c;
            req_n <= ~any_c;
         end
      end
   end else begin : g_comb
      assign code  = code_c;
      assign req_n = ~any_c;
   end
endmodule

// File: rtl/irq_port_unit.sv
module irq_port_unit
   import irq_port_pkg::*;
#(
   parameter int G1_PINS     = 6,
   parameter int G2_PINS     = 9,
   parameter int G3_PINS     = 7,
   parameter int CODE_W      = 4,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 bus_sel,
   input  logic [ADDR_W-1:0]                    bus_addr,
   input  logic                                 bus_wdat,
   input  logic                                 bus_wstb,
   output logic                                 bus_rdat,
   input  logic [G1_PINS+G2_PINS+G3_PINS-1:0]   pin_in,
   output logic [G1_PINS+G2_PINS+G3_PINS-1:0]   pin_out,
   output logic [G1_PINS+G2_PINS+G3_PINS-1:0]   pin_oe,
   output logic [CODE_W-1:0]                    irq_code,
   output logic                                 irq_req_n
);
   localparam int NPIN      = G1_PINS + G2_PINS + G3_PINS;
   localparam int NINT      = G1_PINS + G2_PINS;
   localparam int NPORT     = G2_PINS + G3_PINS;
   localparam int PORT_BASE = 2 ** (ADDR_W - 1);

   if (NINT >= 2 ** CODE_W) begin : g_bad_code
      $error("code width too small for interrupt count");
   end
   if (NINT >= PORT_BASE || NPORT > PORT_BASE) begin : g_bad_addr
      $error("bit address too narrow for pin count");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchroniser needs two or more stages");
   end

   logic [NPIN-1:0]  pin_s;
   logic [NINT-1:0]  irq_en;
   logic [NPORT-1:0] port_val;
   logic [NPORT-1:0] port_dir;
   logic [NPORT-1:0] port_lvl;
   logic [NINT-1:0]  act;
   logic             rd_c;

   irq_port_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   irq_port_regs #(
      .NINT(NINT), .NPORT(NPORT), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wstb(bus_wstb),
      .bus_addr(bus_addr), .bus_wdat(bus_wdat),
      .irq_en(irq_en), .port_val(port_val), .port_dir(port_dir)
   );

   // Pin drive per group
   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      if (p < G1_PINS) begin : g_g1
         assign pin_out[p] = 1'b0;
         assign pin_oe[p]  = 1'b0;
      end else if (p < NINT) begin : g_g2
         localparam int K = pin_port(p, G1_PINS, G2_PINS, G3_PINS);
         assign pin_out[p] = port_val[K];
         assign pin_oe[p]  = port_dir[K];
      end else begin : g_g3
         assign pin_out[p] = port_val[p - NINT];
         assign pin_oe[p]  = port_dir[p - NINT];
      end
   end

   for (genvar k = 0; k < NPORT; k++) begin : g_port_lvl
      localparam int P = port_pin(k, G1_PINS, G2_PINS, G3_PINS);
      assign port_lvl[k] = pin_s[P];
   end

   // An output pin is never an interrupt source
   for (genvar i = 0; i < NINT; i++) begin : g_act
      assign act[i] = irq_en[i] & ~pin_s[i] & ~pin_oe[i];
   end

   irq_port_prio #(.NINT(NINT), .CODE_W(CODE_W), .OUT_REG(OUT_REG)) u_prio (
      .clk(clk), .rst_n(rst_n), .act(act), .code(irq_code), .req_n(irq_req_n)
   );

   always_comb begin
      rd_c = 1'b0;
      for (int i = 0; i < NINT; i++)
         if (int'(bus_addr) == i + 1) rd_c = pin_s[i];
      for (int k = 0; k < NPORT; k++)
         if (int'(bus_addr) == PORT_BASE + k) rd_c = port_lvl[k];
   end

   assign bus_rdat = bus_sel & rd_c;
endmodule

// File: rtl/irq_port_unit_chk.sv
module irq_port_unit_chk #(
   parameter int G1_PINS = 6,
   parameter int G2_PINS = 9,
   parameter int G3_PINS = 7,
   parameter int CODE_W  = 4,
   parameter int ADDR_W  = 5
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               bus_sel,
   input logic [ADDR_W-1:0]                  bus_addr,
   input logic                               bus_wdat,
   input logic                               bus_wstb,
   input logic                               bus_rdat,
   input logic [G1_PINS+G2_PINS+G3_PINS-1:0] pin_in,
   input logic [G1_PINS+G2_PINS+G3_PINS-1:0] pin_out,
   input logic [G1_PINS+G2_PINS+G3_PINS-1:0] pin_oe,
   input logic [CODE_W-1:0]                  irq_code,
   input logic                               irq_req_n
);
   localparam int NINT = G1_PINS + G2_PINS;

   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_n |-> irq_code == '0); // R9
   AST_REQ_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req_n |-> (irq_code != '0 && irq_code <= CODE_W'(NINT))); // R8
   AST_G1_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[G1_PINS-1:0] == '0); // R2
   AST_DIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & $past(pin_oe)) == $past(pin_oe)); // R4
   AST_DIR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe != $past(pin_oe)) |-> $past(bus_sel && bus_wstb)); // R6
   AST_VAL_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0); // R4
   AST_RDAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> !bus_rdat); // R6
endmodule

bind irq_port_unit irq_port_unit_chk #(
   .G1_PINS(G1_PINS), .G2_PINS(G2_PINS), .G3_PINS(G3_PINS),
   .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_irq_port_unit.sv
module test_irq_port_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wdat = 1'b0;
   logic        bus_wstb = 1'b0;
   logic        bus_rdat;
   logic [21:0] ext = {7'h00, 15'h7FFF};
   logic [21:0] pin_in, pin_out, pin_oe;
   logic [3:0]  irq_code;
   logic        irq_req_n;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   irq_port_unit i_irq_port_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_wdat(bus_wdat), .bus_wstb(bus_wstb), .bus_rdat(bus_rdat),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_code(irq_code), .irq_req_n(irq_req_n)
   );

   function automatic int port_pin_exp(int k);
      return (k < 7) ? 15 + k : 21 - k;
   endfunction

   task automatic check(int act, int exp, string req, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, bit v, bit sel = 1'b1);
      @(negedge clk);
      bus_sel = sel; bus_addr = 5'(a); bus_wdat = v; bus_wstb = 1'b1;
      @(negedge clk);
      bus_wstb = 1'b0; bus_sel = 1'b0;
   endtask

   task automatic rd(int a, output bit v);
      @(negedge clk);
      bus_sel = 1'b1; bus_addr = 5'(a);
      #1 v = bus_rdat;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      check(int'(pin_oe), 0, "R1", "pin_oe after reset");
      check(int'(irq_req_n), 1, "R1", "irq_req_n after reset");
      check(int'(irq_code), 0, "R1", "irq_code after reset");
      ext[0] = 1'b0; settle();
      check(int'(irq_req_n), 1, "R1", "enables clear after reset");
      ext[0] = 1'b1; settle();
   endtask

   task automatic t_group1();
      bit v;
      ext[2] = 1'b0; settle();
      rd(3, v); check(int'(v), 0, "R2", "read interrupt 3 low");
      rd(4, v); check(int'(v), 1, "R2", "read interrupt 4 high");
      wr(3, 1'b1); wr(3, 1'b0);
      check(int'(pin_oe[5:0]), 0, "R2", "group one never driven");
      ext[2] = 1'b1; settle();
   endtask

   task automatic t_latency();
      bit v;
      wr(5, 1'b1);
      check(int'(irq_req_n), 1, "R11", "enabled but pin high");
      @(negedge clk); ext[4] = 1'b0;
      bus_sel = 1'b1; bus_addr = 5'd5;
      @(negedge clk);
      check(int'(bus_rdat), 1, "R10", "read one edge after change");
      @(negedge clk);
      check(int'(bus_rdat), 0, "R10", "read two edges after change");
      check(int'(irq_req_n), 1, "R10", "request two edges after change");
      bus_sel = 1'b0;
      @(negedge clk);
      check(int'(irq_req_n), 0, "R10", "request three edges after change");
      check(int'(irq_code), 5, "R7", "code of interrupt 5");
   endtask

   task automatic t_priority();
      ext[1] = 1'b0; settle();
      check(int'(irq_code), 5, "R11", "masked interrupt 2 ignored");
      wr(2, 1'b1); settle();
      check(int'(irq_code), 2, "R8", "lower number wins");
      check(int'(irq_req_n), 0, "R8", "request with two active");
      wr(2, 1'b0); settle();
      check(int'(irq_code), 5, "R3", "disable interrupt 2 by address 2");
      ext[4] = 1'b1; ext[1] = 1'b1; settle();
      check(int'(irq_req_n), 1, "R9", "request idle");
      check(int'(irq_code), 0, "R9", "code idle");
      wr(5, 1'b0);
   endtask

   task automatic t_ports();
      bit v;
      wr(16 + 3, 1'b1);
      check(int'(pin_oe[port_pin_exp(3)]), 1, "R4", "port 3 driven");
      check(int'(pin_out[port_pin_exp(3)]), 1, "R4", "port 3 value");
      settle(); rd(19, v); check(int'(v), 1, "R5", "read port 3");
      wr(19, 1'b0);
      check(int'(pin_oe[port_pin_exp(3)]), 1, "R4", "port 3 stays driven");
      check(int'(pin_out[port_pin_exp(3)]), 0, "R4", "port 3 new value");
      wr(16 + 12, 1'b0);
      check(int'(pin_oe[port_pin_exp(12)]), 1, "R3", "port 12 driven");
      settle(); rd(10, v); check(int'(v), 0, "R5", "port 12 shares interrupt 10");
      wr(16 + 15, 1'b1);
      check(int'(pin_oe[6]), 1, "R5", "port 15 on interrupt 7 pin");
      check(int'(pin_oe), (1 << 6) | (1 << 9) | (1 << 18), "R4", "only written ports driven");
   endtask

   task automatic t_out_no_irq();
      wr(10, 1'b1); settle();
      check(int'(irq_req_n), 1, "R11", "driven low pin raises no request");
      wr(10, 1'b0);
   endtask

   task automatic t_ignored();
      bit v;
      logic [21:0] oe0, out0;
      oe0 = pin_oe; out0 = pin_out;
      wr(0, 1'b1);
      check(int'(pin_oe), int'(oe0), "R3", "address 0 write ignored oe");
      check(int'(pin_out), int'(out0), "R3", "address 0 write ignored out");
      wr(16 + 1, 1'b1, 1'b0);
      check(int'(pin_oe[16]), 0, "R6", "strobe without select ignored");
      wr(1, 1'b1, 1'b0);
      ext[0] = 1'b0; settle();
      check(int'(irq_req_n), 1, "R6", "enable write without select ignored");
      ext[0] = 1'b1; settle();
      @(negedge clk); bus_addr = 5'd1; #1;
      check(int'(bus_rdat), 0, "R6", "read data idle without select");
      rd(0, v); check(int'(v), 0, "R3", "address 0 reads 0");
   endtask

   task automatic t_reset_again();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check(int'(pin_oe), 0, "R4", "reset returns pins to input");
      check(int'(pin_out), 0, "R1", "reset clears values");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_group1();
      t_latency();
      t_priority();
      t_ports();
      t_out_no_irq();
      t_ignored();
      t_reset_again();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule